// File: doc/BRIEF.md
# Two-Phase Micropipeline Control

This block is a clocked model of a chain of bundled-data stages that hand words forward with transition signalling. Each stage pairs a rendezvous element with a data register. The rendezvous element takes the stage's incoming request and the inverted state of the next stage. The stage's state bit toggles when a new request is present and the next stage has already taken the previous word. On that toggle the stage captures its input word and acknowledges its sender.

A stage holds a word whenever its state bit differs from that of its successor. For the last stage the successor is the downstream acknowledge. A stage is empty when the two are equal. The model uses no per-word enable and no occupancy counter. Each forward request between stages, and toward the output, passes through a configurable number of register cycles. These cycles stand in for the matched delay that lets data settle before its request arrives.

Both edge directions of every request and acknowledge carry the same meaning: a transition is an event. An upstream sender toggles `rin` with the word on `din` and holds the word until `ain` matches `rin` again. A downstream receiver sees a word on `dout` while `rout` differs from `aout`, and frees it by toggling `aout`.

Top module: `upipe_ctrl`

## Requirements
- R1: A stage's state bit toggles only in a cycle in which its request differs from its state and its successor's state equals its state.
- R2: After synchronous reset, `ain` and `rout` are 0 and the pipeline is empty, with `aout` held at 0 by the receiver.
- R3: A `rin` transition into an empty first stage makes `ain` equal `rin` exactly one clock later. `ain` never changes unless `rin` differed from it in the previous cycle.
- R4: In an empty pipeline, `rout` toggles exactly STAGES*(REQ_DELAY+1) clock cycles after the `rin` transition, and not one cycle earlier.
- R5: With `aout` held, at most STAGES words are accepted. A further `rin` transition gets no `ain` transition until `aout` toggles. `rout` changes only while it equals `aout`.
- R6: While `rout` differs from `aout`, `dout` holds the oldest undelivered word and stays stable until `aout` toggles.
- R7: Under arbitrary interleavings of sender and receiver transitions, every accepted word is delivered once, in order, with no loss.
- R8: The number of accepted but undelivered words never exceeds STAGES.
- R9: Rising and falling transitions of `rin` are both requests. Two consecutive words, one sent on each edge direction, are both delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rin | input | 1 | Upstream request, one transition per word |
| din | input | WIDTH | Upstream word, held until acknowledged |
| ain | output | 1 | Upstream acknowledge, toggles when the word is taken |
| rout | output | 1 | Downstream request, toggles when a word is presented |
| dout | output | WIDTH | Downstream word |
| aout | input | 1 | Downstream acknowledge, toggles to free the word |

## Verification
A single word sent into an empty pipeline measures the forward latency. This test tells a missing or extra delay register apart from a correct chain, and it also shows the one-cycle acknowledge. Back-to-back words sent on opposite edges of `rin` check that both transition directions count as events. A test that holds the receiver still fills every stage and then offers one more word. It separates a correct stall from a design that overwrites a full stage or acknowledges too early, and the following drain shows that the held words come out in order. A long run of random sender and receiver transitions, checked against a reference queue, exposes loss, duplication, reordering or overfill that arise only under uneven timing.

// File: rtl/upipe_pkg.sv
package upipe_pkg;
  // A slot holds a word when its state bit and its successor's differ.
  function automatic logic slot_full(input logic own_state, input logic succ_state);
    return own_state ^ succ_state;
  endfunction
endpackage

// File: rtl/upipe_celem.sv
module upipe_celem (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic succ_i,
  output logic state_o,
  output logic fire_o
);
  logic state_q;
  logic succ_n;

  // second input is inverted: element follows when both inputs agree
  assign succ_n  = ~succ_i;
  assign fire_o  = (req_i == succ_n) && (req_i != state_q);
  assign state_o = state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= 1'b0;
    end else if (fire_o) begin
      state_q <= req_i;
    end
  end

  assert_toggle_guard_R1: assert property (@(posedge clk) disable iff (rst)
    (state_q != $past(state_q)) |->
      ($past(req_i) != $past(state_q) && $past(succ_i) == $past(state_q)))
    else $error("R1: state toggled without request or with a full successor");
endmodule

// File: rtl/upipe_delay.sv
module upipe_delay #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic sig_o
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign sig_o = sig_i;
    end else begin : g_regs
      logic [DEPTH-1:0] taps_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          taps_q <= '0;
        end else begin
          taps_q[0] <= sig_i;
          for (int j = 1; j < int'(DEPTH); j++) begin
            taps_q[j] <= taps_q[j-1];
          end
        end
      end
      assign sig_o = taps_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/upipe_stage.sv
module upipe_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             succ_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             state_o,
  output logic [WIDTH-1:0] word_o
);
  logic             fire;
  logic             full;
  logic [WIDTH-1:0] word_q;

  upipe_celem u_celem (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_i),
    .succ_i (succ_i),
    .state_o(state_o),
    .fire_o (fire)
  );

  assign full = upipe_pkg::slot_full(state_o, succ_i);

  // capture on the request event only
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (fire) begin
      word_q <= word_i;
    end
  end

  assign word_o = word_q;

  assert_hold_while_full_R6: assert property (@(posedge clk) disable iff (rst)
    (full && $past(full)) |-> $stable(word_q))
    else $error("R6: stage word changed while the stage stayed full");
endmodule

// File: rtl/upipe_ctrl.sv
module upipe_ctrl #(
  parameter int unsigned STAGES    = 3,
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned REQ_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rin,
  input  logic [WIDTH-1:0] din,
  output logic             ain,
  output logic             rout,
  output logic [WIDTH-1:0] dout,
  input  logic             aout
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] st;
  logic [STAGES-1:0] req;
  logic [STAGES-1:0] succ;
  logic [STAGES-1:0] dreq;
  logic [WIDTH-1:0]  word [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign req[i] = rin;
        upipe_stage #(.WIDTH(WIDTH)) u_stage (
          .clk(clk), .rst(rst), .req_i(req[i]), .succ_i(succ[i]),
          .word_i(din), .state_o(st[i]), .word_o(word[i]));
      end else begin : g_body
        assign req[i] = dreq[i-1];
        upipe_stage #(.WIDTH(WIDTH)) u_stage (
          .clk(clk), .rst(rst), .req_i(req[i]), .succ_i(succ[i]),
          .word_i(word[i-1]), .state_o(st[i]), .word_o(word[i]));
      end

      if (i == LAST) begin : g_tail
        assign succ[i] = aout;
      end else begin : g_link
        assign succ[i] = st[i+1];
      end

      // matched delay on every forward request
      upipe_delay #(.DEPTH(REQ_DELAY)) u_dly (
        .clk(clk), .rst(rst), .sig_i(st[i]), .sig_o(dreq[i]));
    end
  endgenerate

  assign ain  = st[0];
  assign rout = dreq[LAST];
  assign dout = word[LAST];

  assert_reset_empty_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ain && !rout))
    else $error("R2: handshake outputs not idle after reset");

  assert_ack_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
    (ain != $past(ain)) |-> ($past(rin) != $past(ain)))
    else $error("R3: ain toggled with no pending request");

  assert_rout_after_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (rout != $past(rout)) |-> ($past(rout) == $past(aout)))
    else $error("R5: rout toggled while previous word unacknowledged");

  assert_dout_stable_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(rout) != $past(aout) && rout == $past(rout)) |-> $stable(dout))
    else $error("R6: dout changed while presented word pending");
endmodule

// File: tb/upipe_ctrl_test.sv
module upipe_ctrl_test;
  localparam int unsigned NST  = 3;
  localparam int unsigned W    = 8;
  localparam int unsigned DLY  = 2;
  localparam int unsigned LAT  = NST * (DLY + 1);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rin = 1'b0;
  logic [W-1:0] din = '0;
  logic         ain;
  logic         rout;
  logic [W-1:0] dout;
  logic         aout = 1'b0;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  upipe_ctrl #(.STAGES(NST), .WIDTH(W), .REQ_DELAY(DLY)) uut (
    .clk(clk), .rst(rst), .rin(rin), .din(din), .ain(ain),
    .rout(rout), .dout(dout), .aout(aout));

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [W-1:0] val, input int limit, output bit taken);
    din = val;
    rin = ~rin;
    taken = 1'b0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (ain == rin) begin
        taken = 1'b1;
        break;
      end
    end
  endtask

  task automatic recv_word(input logic [W-1:0] exp, input string tag);
    bit seen = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (rout != aout) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
    check(seen, {tag, " word presented"}, seen, 1);
    check(dout == exp, {tag, " word order"}, dout, exp);
    aout = ~aout;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(ain == 1'b0, "R2 ain after reset", ain, 0);
    check(rout == 1'b0, "R2 rout after reset", rout, 0);
  endtask

  task automatic t_latency(input logic [W-1:0] val, input string tag);
    logic old_rout;
    old_rout = rout;
    din = val;
    rin = ~rin;
    @(negedge clk);
    check(ain == rin, {tag, " R3 ain one cycle after rin"}, ain, rin);
    for (int k = 0; k < int'(LAT) - 2; k++) @(negedge clk);
    check(rout == old_rout, {tag, " R4 rout not yet toggled"}, rout, old_rout);
    @(negedge clk);
    check(rout != old_rout, {tag, " R4 rout toggled at latency"}, rout, !old_rout);
    check(dout == val, {tag, " R6 dout with rout"}, dout, val);
    aout = ~aout;
    @(negedge clk);
  endtask

  task automatic t_stall();
    bit taken;
    for (int n = 0; n < int'(NST); n++) begin
      send_word(W'(8'h40 + n), 60, taken);
      check(taken, "R5 fill stage accepted", taken, 1);
    end
    send_word(8'h4F, 60, taken);
    check(!taken, "R5 extra word held off", taken, 0);
    check(ain != rin, "R5 ain unchanged while full", ain, !rin);
    check(rout != aout, "R6 word pending during stall", rout, !aout);
    for (int n = 0; n < int'(NST); n++) recv_word(W'(8'h40 + n), "R7 drain");
    recv_word(8'h4F, "R5 held word after release");
    check(ain == rin, "R5 held word acknowledged", ain, rin);
  endtask

  task automatic t_random();
    logic [W-1:0] q[$];
    int sent = 0, accepted = 0, delivered = 0, maxocc = 0;
    logic prev_ain;
    prev_ain = ain;
    for (int cyc = 0; cyc < 20000 && delivered < 300; cyc++) begin
      @(negedge clk);
      if (ain != prev_ain) accepted++;
      prev_ain = ain;
      if (accepted - delivered > maxocc) maxocc = accepted - delivered;
      if (rout != aout && ($urandom % 2) == 0) begin
        check(q.size() > 0 && dout == q[0], "R7 random order", dout, q.size() > 0 ? q[0] : 0);
        if (q.size() > 0) void'(q.pop_front());
        delivered++;
        aout = ~aout;
      end
      if (rin == ain && sent < 300 && ($urandom % 3) != 0) begin
        logic [W-1:0] v;
        v = W'($urandom);
        q.push_back(v);
        din = v;
        rin = ~rin;
        sent++;
      end
    end
    check(delivered == 300, "R7 all words delivered", delivered, 300);
    check(maxocc <= int'(NST), "R8 occupancy bound", maxocc, NST);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency(8'hA5, "R9 rising");
    t_latency(8'h3C, "R9 falling");
    t_stall();
    t_random();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule